// File: doc/BRIEF.md
# Serial DAC Command Word Receiver

This block accepts 24-bit command words from a host over a three-wire serial link: an active-low frame-sync, a serial clock and a data line. All three inputs are brought into the system clock domain through two-flop synchronisers. Data is sampled on each detected falling serial-clock edge, and the first bit sent is the most significant. A falling frame-sync arms the receiver and clears its bit counter. In standalone mode the word is committed as soon as the 24th bit arrives, and later serial clocks are locked out until the next falling frame-sync.

With the cascade input high, the receiver keeps shifting for as long as the frame lasts. The top bit of its shift register leaves on the serial output, so several receivers can be chained and each one passes on the stream 24 bits late. In this mode the word is committed when frame-sync rises. On every commit a one-cycle strobe is raised. The decoded fields are a bank select, a read/write flag, a channel number, a register selector and a 12-bit value. They stay steady until the next commit.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset the strobe, all decoded fields and the serial output are 0.
- R2: In the committed word (bit 23 first on the wire), bit 23 drives `bank_b`, bit 22 drives `rd_wr`, bits 21..16 drive `chan`, bits 15..14 drive `reg_sel` and bits 13..2 drive `value`. Bits 1..0 are discarded.
- R3: In standalone mode a frame of exactly 24 falling serial-clock edges after a falling frame-sync produces exactly one `cmd_valid` pulse, one system clock long.
- R4: In standalone mode, serial-clock edges after the 24th bit change neither the fields nor the strobe until the next falling frame-sync.
- R5: In standalone mode a rising frame-sync before the 24th bit is ignored. Bits clocked after it still complete the word.
- R6: A falling frame-sync in mid-frame discards the partial word and restarts the count.
- R7: Serial-clock edges that arrive when no frame is armed (a free-running clock) have no effect.
- R8: The serial output is 0 in standalone mode. In cascade mode it carries the most significant bit of the shift register, so the input stream reappears delayed by 24 bits.
- R9: In cascade mode the word is committed on the rising frame-sync, and it holds the last 24 bits shifted in.
- R10: Between commits the decoded fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_n | input | 1 | Active-low frame-sync from the host |
| sclk | input | 1 | Serial clock, gated or free-running |
| sdi | input | 1 | Serial data in, MSB first |
| casc_en | input | 1 | 1 selects cascade mode, 0 selects standalone mode |
| sdo | output | 1 | Serial data out in cascade mode |
| cmd_valid | output | 1 | One-cycle commit strobe |
| bank_b | output | 1 | Bank select, 0 = bank A |
| rd_wr | output | 1 | Read/write flag |
| chan | output | 6 | Channel address |
| reg_sel | output | 2 | Register selector |
| value | output | 12 | Data value |

## Verification
The hardest situations to reach are the ones where frame-sync moves in the middle of a word. One is a rise that must be ignored while the remaining bits are clocked with sync high. The other is a second fall that must discard a partial word. Dedicated tasks split a frame at chosen bit counts and drive each of these orders. They also run extra serial clocks past bit 24 and serial clocks outside any frame, then confirm at the outputs that the strobe count and the fields did not move. In cascade mode the bench sends two words back to back and compares the serial output bit by bit against the first word while the second is shifting in.

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx #(
  parameter int W     = 24,
  parameter int CHW   = 6,
  parameter int RSW   = 2,
  parameter int DW    = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fsync_n,
  input  logic           sclk,
  input  logic           sdi,
  input  logic           casc_en,
  output logic           sdo,
  output logic           cmd_valid,
  output logic           bank_b,
  output logic           rd_wr,
  output logic [CHW-1:0] chan,
  output logic [RSW-1:0] reg_sel,
  output logic [DW-1:0]  value
);
  localparam int CNTW = $clog2(W + 1);
  localparam int PAD  = W - 2 - CHW - RSW - DW;
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(W);

  logic [2:0]      fs_q, sc_q;
  logic [1:0]      di_q;
  logic            armed;
  logic [CNTW-1:0] cnt;
  logic [W-1:0]    sr, word;

  wire fs_fall = fs_q[2] & ~fs_q[1];
  wire fs_rise = ~fs_q[2] & fs_q[1];
  wire sc_fall = sc_q[2] & ~sc_q[1];
  wire [W-1:0] nxt = {sr[W-2:0], di_q[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= '1;
      sc_q <= '1;
      di_q <= '0;
    end else begin
      fs_q <= {fs_q[1:0], fsync_n};
      sc_q <= {sc_q[1:0], sclk};
      di_q <= {di_q[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt       <= '0;
      sr        <= '0;
      word      <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (fs_fall) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (sc_fall) begin
          sr <= nxt;
          if (cnt != FULL) cnt <= cnt + 1'b1;
          if (!casc_en && cnt == LAST) begin
            word      <= nxt;
            cmd_valid <= 1'b1;
            armed     <= 1'b0;
          end
        end else if (casc_en && fs_rise) begin
          word      <= sr;
          cmd_valid <= 1'b1;
          armed     <= 1'b0;
        end
      end
    end
  end

  assign sdo     = casc_en & sr[W-1];
  assign bank_b  = word[W-1];
  assign rd_wr   = word[W-2];
  assign chan    = word[W-3 -: CHW];
  assign reg_sel = word[W-3-CHW -: RSW];
  assign value   = word[W-3-CHW-RSW -: DW];

  wire unused_ok = ^{word[PAD-1:0], 1'b0};
endmodule

module dac_cmd_rx_chk #(
  parameter int W    = 24,
  parameter int CNTW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            casc_en,
  input logic            sdo,
  input logic            cmd_valid,
  input logic            armed,
  input logic [CNTW-1:0] cnt,
  input logic [W-1:0]    word
);
  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);                                        // R3
  AST_STROBE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !armed && $past(armed));                            // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(W));                                                 // R4
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !casc_en |-> !sdo);                                               // R8
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(word));                                    // R10
endmodule

bind dac_cmd_rx dac_cmd_rx_chk #(.W(W), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .casc_en(casc_en), .sdo(sdo),
  .cmd_valid(cmd_valid), .armed(armed), .cnt(cnt), .word(word));

// File: tb/sim_dac_cmd_rx.sv
module sim_dac_cmd_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync_n = 1'b1, sclk = 1'b1, sdi = 1'b0, casc_en = 1'b0;
  logic sdo, cmd_valid, bank_b, rd_wr;
  logic [5:0] chan;
  logic [1:0] reg_sel;
  logic [11:0] value;
  int total = 0, bad = 0, vcnt = 0;

  always #4 clk = ~clk;

  dac_cmd_rx u0 (.clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .sclk(sclk),
    .sdi(sdi), .casc_en(casc_en), .sdo(sdo), .cmd_valid(cmd_valid),
    .bank_b(bank_b), .rd_wr(rd_wr), .chan(chan), .reg_sel(reg_sel), .value(value));

  always @(negedge clk) if (rst_n && cmd_valid) vcnt++;

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_word(string req, logic [23:0] w);
    check(req, {31'd0, bank_b}, {31'd0, w[23]});
    check(req, {31'd0, rd_wr}, {31'd0, w[22]});
    check(req, {26'd0, chan}, {26'd0, w[21:16]});
    check(req, {30'd0, reg_sel}, {30'd0, w[15:14]});
    check(req, {20'd0, value}, {20'd0, w[13:2]});
  endtask

  task automatic bit_out(logic b);
    sdi = b; sclk = 1'b1; wt(4);
    sclk = 1'b0; wt(4);
    sclk = 1'b1;
  endtask

  task automatic bits(logic [23:0] w, int from, int n);
    for (int i = 0; i < n; i++) bit_out(w[23 - from - i]);
  endtask

  task automatic frame(logic [23:0] w);
    fsync_n = 1'b0; wt(4);
    bits(w, 0, 24);
    wt(4); fsync_n = 1'b1; wt(8);
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, cmd_valid}, 0);
    check_word("R1", 24'h0);
    check("R1 sdo", {31'd0, sdo}, 0);
  endtask

  task automatic t_basic;
    int v0 = vcnt;
    frame(24'hA5C3F1);
    check_word("R2", 24'hA5C3F1);
    check("R3 pulses", vcnt - v0, 1);
    frame(24'h5A3C0E);
    check_word("R2 second", 24'h5A3C0E);
    check("R3 pulses2", vcnt - v0, 2);
    check("R8 standalone sdo", {31'd0, sdo}, 0);
  endtask

  task automatic t_extra;
    int v0 = vcnt;
    fsync_n = 1'b0; wt(4);
    bits(24'h3FF00C, 0, 24);
    for (int i = 0; i < 6; i++) bit_out(1'b1);
    wt(4);
    check_word("R4", 24'h3FF00C);
    check("R4 pulses", vcnt - v0, 1);
    fsync_n = 1'b1; wt(8);
    wt(40);
    check_word("R10", 24'h3FF00C);
  endtask

  task automatic t_mid_rise;
    int v0 = vcnt;
    fsync_n = 1'b0; wt(4);
    bits(24'hC0FFEE, 0, 10);
    fsync_n = 1'b1; wt(8);
    check("R5 no early commit", vcnt - v0, 0);
    bits(24'hC0FFEE, 10, 14);
    wt(8);
    check_word("R5", 24'hC0FFEE);
    check("R5 pulses", vcnt - v0, 1);
  endtask

  task automatic t_restart;
    int v0 = vcnt;
    fsync_n = 1'b0; wt(4);
    bits(24'hFFFFFF, 0, 7);
    fsync_n = 1'b1; wt(4);
    fsync_n = 1'b0; wt(4);
    bits(24'h12345C, 0, 24);
    wt(4); fsync_n = 1'b1; wt(8);
    check_word("R6", 24'h12345C);
    check("R6 pulses", vcnt - v0, 1);
  endtask

  task automatic t_free_clk;
    int v0 = vcnt;
    for (int i = 0; i < 30; i++) bit_out(i[0]);
    check("R7 no commit", vcnt - v0, 0);
    check_word("R7 hold", 24'h12345C);
    fsync_n = 1'b0; wt(4);
    bits(24'h81818F, 0, 24);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    fsync_n = 1'b1; wt(8);
    check_word("R7", 24'h81818F);
  endtask

  task automatic t_cascade;
    logic [23:0] a = 24'hB4E21D, b = 24'h6D19A6;
    int v0, errs = 0;
    casc_en = 1'b1; wt(4);
    v0 = vcnt;
    fsync_n = 1'b0; wt(4);
    bits(a, 0, 24);
    check("R9 no commit at 24", vcnt - v0, 0);
    for (int k = 0; k < 24; k++) begin
      if (sdo !== a[23 - k]) errs++;
      bit_out(b[23 - k]);
    end
    check("R8 sdo delayed stream mismatches", errs, 0);
    wt(4); fsync_n = 1'b1; wt(8);
    check_word("R9", b);
    check("R9 pulses", vcnt - v0, 1);
    casc_en = 1'b0; wt(2);
    check("R8 sdo off", {31'd0, sdo}, 0);
  endtask

  initial begin
    wt(3);
    t_reset();
    rst_n = 1'b1; wt(4);
    t_basic();
    t_extra();
    t_mid_rise();
    t_restart();
    t_free_clk();
    t_cascade();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule